// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows one processor core through its clock-stop and sleep states. The platform drives it through active-low request lines: clock-stop, deep-sleep, deeper-reset and a platform reset. A handful of handshake inputs stand in for the internal bus: a snoop or interrupt arriving, a snoop being finished by any agent, an interrupt being captured, and the acknowledge cycle's response. The block has five states: Normal, Stop-Grant, Stop-Grant Snoop, Sleep and Deep Sleep. It publishes the current state on a 3-bit output. It raises a stop acknowledge when a clock-stop is requested, and it marks when the platform is allowed to halt the bus clock.

Entry into Stop-Grant happens a fixed, parameterised number of cycles after the acknowledge response. That number never exceeds the 1384-cycle ceiling. Bus activity while stopped sends the core into a snoop detour, and the core comes back out to Stop-Grant. Sleep is reached from Stop-Grant through a separate sleep request. Deep Sleep is reached only from Sleep. Leaving Deep Sleep waits out a programmable clock-restart settle time. A platform reset clears all pending handshakes at once but leaves a stopped core in Stop-Grant. A reset released while any request is still asserted sets a sticky sequencing error.

Top module: `lps_ctrl`

## Requirements
- R1: After `rst` the state output reads 0 (Normal), and `stop_ack`, `clk_stop_ok` and `seq_err` are all low.
- R2: In Normal with no entry under way, a low `clkstop_req_n` raises `stop_ack` from the next cycle. `stop_ack` stays high until `ack_done` is sampled high, and it is high only while the state is Normal.
- R3: The state becomes 1 (Stop-Grant) exactly `ENTRY_CYC` cycles after the edge that samples `ack_done`. The wait never lasts more than 1384 cycles.
- R4: A high `clkstop_req_n` in Stop-Grant returns the state to 0. Before entry completes, a high `clkstop_req_n` cancels the entry: `stop_ack` drops and the state stays 0.
- R5: In Stop-Grant, `snoop_req` or `intr_req` moves the state to 2 (Snoop) on the next edge. This takes priority over a clock-stop release and over a sleep request.
- R6: The state stays 2 until `snoop_done` or `intr_latched` is sampled high, and then it returns to 1.
- R7: `sleep_req` in Stop-Grant moves the state to 3 (Sleep). Dropping `sleep_req` in Sleep returns the state to 1.
- R8: A low `dsleep_req_n` in Sleep moves the state to 4 (Deep Sleep) on the next edge. In any other state, a low `dsleep_req_n` has no effect on the state.
- R9: `clk_stop_ok` is high one cycle after the edge at which Deep Sleep is requested, which is inside the two-cycle limit. It stays high while in Deep Sleep until a restart begins.
- R10: A high `dsleep_req_n` in Deep Sleep drops `clk_stop_ok` at once. The state returns to 3 exactly `RESTART_CYC` cycles after that edge.
- R11: While `sys_rst_n` is low, any pending acknowledge or count is cleared. A state of 1 or 2 becomes 1, and every other state becomes 0. The state then holds while the reset stays low.
- R12: If `sys_rst_n` rises while `clkstop_req_n`, `dsleep_req_n` or `dreset_req_n` is low, `seq_err` goes high on the next edge. It stays high until `rst` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_rst_n | input | 1 | Platform reset, active low |
| clkstop_req_n | input | 1 | Clock-stop request, active low |
| dsleep_req_n | input | 1 | Deep-sleep request, active low |
| dreset_req_n | input | 1 | Deeper-reset request, active low |
| sleep_req | input | 1 | Sleep request, active high |
| ack_done | input | 1 | Stop acknowledge response has completed |
| snoop_req | input | 1 | Snoop pending on internal bus |
| intr_req | input | 1 | Interrupt delivery pending on internal bus |
| snoop_done | input | 1 | Snoop serviced by this core or another agent |
| intr_latched | input | 1 | Pending interrupt has been captured |
| lp_state | output | 3 | Current state: 0 Normal, 1 Stop-Grant, 2 Snoop, 3 Sleep, 4 Deep Sleep |
| stop_ack | output | 1 | Stop acknowledge in progress |
| clk_stop_ok | output | 1 | Bus clock may be halted |
| seq_err | output | 1 | Sticky reset sequencing error |

## Verification
The assertions assume `ENTRY_CYC` and `RESTART_CYC` are at least 1 and that `ENTRY_CYC` stays within the 1384-cycle ceiling. They also assume that snoop completion inputs are only meaningful while a detour is open, and that `sleep_req` is held for as long as Sleep or Deep Sleep should last. The stimulus changes inputs only just after a clock edge, and it raises each handshake input for one cycle at a point where the state it targets is already present. Platform reset is released with the requests cleared, except in the one scenario that provokes the sequencing error on purpose.

// File: rtl/lps_pkg.sv
`timescale 1ns/1ps
package lps_pkg;

    localparam int unsigned LPS_MAX_ENTRY = 1384;

    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_STOPGRANT = 3'd1,
        ST_SNOOP     = 3'd2,
        ST_SLEEP     = 3'd3,
        ST_DEEP      = 3'd4
    } lps_state_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACK  = 2'd1,
        PH_WAIT = 2'd2
    } entry_phase_e;

    typedef struct packed {
        lps_state_e   state;
        entry_phase_e phase;
    } lps_ctrl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic is_stopped(input lps_state_e s);
        return (s == ST_STOPGRANT) || (s == ST_SNOOP);
    endfunction

endpackage

// File: rtl/lps_delay_cnt.sv
`timescale 1ns/1ps
module lps_delay_cnt #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int unsigned W = lps_pkg::cnt_width(LEN);
    localparam logic [W-1:0] LOAD = W'(LEN);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || abort)      cnt_q <= '0;
        else if (start)        cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == W'(1));

    // R3 R10: a count never rises except on a load
    p_cnt_down_r10: assert property (@(posedge clk) disable iff (rst)
        (!start && !abort && busy) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/lps_seq_mon.sv
`timescale 1ns/1ps
module lps_seq_mon (
    input  logic clk,
    input  logic rst,
    input  logic sys_rst_n,
    input  logic clkstop_req_n,
    input  logic dsleep_req_n,
    input  logic dreset_req_n,
    output logic seq_err
);
    logic rst_seen_q;
    logic err_q;
    logic release_edge;
    logic any_req;

    assign release_edge = sys_rst_n && !rst_seen_q;
    assign any_req      = !clkstop_req_n || !dsleep_req_n || !dreset_req_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_seen_q <= 1'b1;
            err_q      <= 1'b0;
        end else begin
            rst_seen_q <= sys_rst_n;
            if (release_edge && any_req) err_q <= 1'b1;
        end
    end

    assign seq_err = err_q;

    // R12: flag is sticky
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);
    // R12: a bad release is always caught
    p_bad_release_r12: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_n && !$past(sys_rst_n) &&
         (!clkstop_req_n || !dsleep_req_n || !dreset_req_n)) |=> seq_err);
endmodule

// File: rtl/lps_ctrl.sv
`timescale 1ns/1ps
module lps_ctrl #(
    parameter int unsigned ENTRY_CYC   = 6,
    parameter int unsigned RESTART_CYC = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_rst_n,
    input  logic       clkstop_req_n,
    input  logic       dsleep_req_n,
    input  logic       dreset_req_n,
    input  logic       sleep_req,
    input  logic       ack_done,
    input  logic       snoop_req,
    input  logic       intr_req,
    input  logic       snoop_done,
    input  logic       intr_latched,
    output logic [2:0] lp_state,
    output logic       stop_ack,
    output logic       clk_stop_ok,
    output logic       seq_err
);
    import lps_pkg::*;

    localparam int unsigned WW = cnt_width(LPS_MAX_ENTRY + 1);

    lps_ctrl_t cur_q, nxt;
    logic entry_start, entry_abort, entry_busy, entry_done;
    logic rs_start, rs_abort, rs_busy, rs_done;

    lps_delay_cnt #(.LEN(ENTRY_CYC)) u_entry (
        .clk(clk), .rst(rst), .start(entry_start), .abort(entry_abort),
        .busy(entry_busy), .done(entry_done));

    lps_delay_cnt #(.LEN(RESTART_CYC)) u_restart (
        .clk(clk), .rst(rst), .start(rs_start), .abort(rs_abort),
        .busy(rs_busy), .done(rs_done));

    lps_seq_mon u_seq (
        .clk(clk), .rst(rst), .sys_rst_n(sys_rst_n),
        .clkstop_req_n(clkstop_req_n), .dsleep_req_n(dsleep_req_n),
        .dreset_req_n(dreset_req_n), .seq_err(seq_err));

    always_comb begin
        nxt         = cur_q;
        entry_start = 1'b0;
        entry_abort = 1'b0;
        rs_start    = 1'b0;
        rs_abort    = 1'b0;
        if (!sys_rst_n) begin
            nxt.phase   = PH_IDLE;
            entry_abort = 1'b1;
            rs_abort    = 1'b1;
            nxt.state   = is_stopped(cur_q.state) ? ST_STOPGRANT : ST_NORMAL;
        end else begin
            unique case (cur_q.state)
                ST_NORMAL: begin
                    unique case (cur_q.phase)
                        PH_IDLE: if (!clkstop_req_n) nxt.phase = PH_ACK;
                        PH_ACK: begin
                            if (clkstop_req_n) nxt.phase = PH_IDLE;
                            else if (ack_done) begin
                                nxt.phase   = PH_WAIT;
                                entry_start = 1'b1;
                            end
                        end
                        PH_WAIT: begin
                            if (clkstop_req_n) begin
                                nxt.phase   = PH_IDLE;
                                entry_abort = 1'b1;
                            end else if (entry_done) begin
                                nxt.state = ST_STOPGRANT;
                                nxt.phase = PH_IDLE;
                            end
                        end
                        default: nxt.phase = PH_IDLE;
                    endcase
                end
                ST_STOPGRANT: begin
                    if (snoop_req || intr_req) nxt.state = ST_SNOOP;
                    else if (clkstop_req_n)    nxt.state = ST_NORMAL;
                    else if (sleep_req)        nxt.state = ST_SLEEP;
                end
                ST_SNOOP: begin
                    if (snoop_done || intr_latched) nxt.state = ST_STOPGRANT;
                end
                ST_SLEEP: begin
                    if (!dsleep_req_n)  nxt.state = ST_DEEP;
                    else if (!sleep_req) nxt.state = ST_STOPGRANT;
                end
                ST_DEEP: begin
                    if (!rs_busy) begin
                        if (dsleep_req_n) rs_start = 1'b1;
                    end else if (!dsleep_req_n) begin
                        rs_abort = 1'b1;
                    end else if (rs_done) begin
                        nxt.state = ST_SLEEP;
                    end
                end
                default: nxt.state = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.state <= ST_NORMAL;
            cur_q.phase <= PH_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    assign lp_state    = cur_q.state;
    assign stop_ack    = (cur_q.phase == PH_ACK);
    assign clk_stop_ok = (cur_q.state == ST_DEEP) && !rs_busy;

    // R3 entry latency bound, tracked by a counter rather than a long delay
    logic [WW-1:0] wait_cnt_q;
    always_ff @(posedge clk) begin
        if (rst || cur_q.phase != PH_WAIT) wait_cnt_q <= '0;
        else if (wait_cnt_q != '1)         wait_cnt_q <= wait_cnt_q + 1'b1;
    end
    p_entry_bound_r3: assert property (@(posedge clk) disable iff (rst)
        wait_cnt_q <= WW'(LPS_MAX_ENTRY));
    p_wait_counts_r3: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_WAIT) |-> entry_busy);
    // R2 acknowledge only from Normal
    p_ack_normal_r2: assert property (@(posedge clk) disable iff (rst)
        stop_ack |-> (lp_state == 3'd0));
    // R6 snoop detour holds until serviced
    p_snoop_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (lp_state == 3'd2 && sys_rst_n && !snoop_done && !intr_latched)
        |=> (lp_state == 3'd2));
    // R8 Deep Sleep is only reached from Sleep
    p_deep_from_sleep_r8: assert property (@(posedge clk) disable iff (rst)
        (lp_state != 3'd4) |=> (lp_state != 3'd4) || ($past(lp_state) == 3'd3));
    // R9 clock-stop permit follows deep-sleep entry
    p_stop_ok_r9: assert property (@(posedge clk) disable iff (rst)
        (lp_state == 3'd3 && !dsleep_req_n && sys_rst_n) |=> clk_stop_ok);
    // R11 stopped core stays stopped under platform reset
    p_rst_keeps_sg_r11: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst_n && (lp_state == 3'd1 || lp_state == 3'd2)) |=> (lp_state == 3'd1));
endmodule

// File: tb/lps_ctrl_tb.sv
`timescale 1ns/1ps
module lps_ctrl_tb;
    localparam int ENTRY_CYC   = 6;
    localparam int RESTART_CYC = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_rst_n = 1'b1, clkstop_req_n = 1'b1, dsleep_req_n = 1'b1, dreset_req_n = 1'b1;
    logic sleep_req = 1'b0, ack_done = 1'b0, snoop_req = 1'b0, intr_req = 1'b0;
    logic snoop_done = 1'b0, intr_latched = 1'b0;
    logic [2:0] lp_state;
    logic stop_ack, clk_stop_ok, seq_err;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lps_ctrl #(.ENTRY_CYC(ENTRY_CYC), .RESTART_CYC(RESTART_CYC)) u_dut (
        .clk(clk), .rst(rst), .sys_rst_n(sys_rst_n), .clkstop_req_n(clkstop_req_n),
        .dsleep_req_n(dsleep_req_n), .dreset_req_n(dreset_req_n), .sleep_req(sleep_req),
        .ack_done(ack_done), .snoop_req(snoop_req), .intr_req(intr_req),
        .snoop_done(snoop_done), .intr_latched(intr_latched), .lp_state(lp_state),
        .stop_ack(stop_ack), .clk_stop_ok(clk_stop_ok), .seq_err(seq_err));

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic go_stopgrant();
        clkstop_req_n = 1'b0;
        step();
        chk("R2 ack raised", stop_ack, 1);
        step(2);
        chk("R2 ack held", stop_ack, 1);
        ack_done = 1'b1;
        step();
        ack_done = 1'b0;
        chk("R2 ack drops", stop_ack, 0);
        step(ENTRY_CYC - 1);
        chk("R3 not early", lp_state, 0);
        step();
        chk("R3 entry exact", lp_state, 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state", lp_state, 0);
        chk("R1 ack", stop_ack, 0);
        chk("R1 stop ok", clk_stop_ok, 0);
        chk("R1 err", seq_err, 0);
    endtask

    task automatic t_entry_exit();
        go_stopgrant();
        clkstop_req_n = 1'b1;
        step();
        chk("R4 exit to normal", lp_state, 0);
        clkstop_req_n = 1'b0;
        step();
        ack_done = 1'b1;
        step();
        ack_done = 1'b0;
        step(2);
        clkstop_req_n = 1'b1;
        step();
        chk("R4 cancel wait state", lp_state, 0);
        step(ENTRY_CYC + 2);
        chk("R4 cancel stays normal", lp_state, 0);
        clkstop_req_n = 1'b0;
        step();
        clkstop_req_n = 1'b1;
        step();
        chk("R4 cancel ack", stop_ack, 0);
    endtask

    task automatic t_snoop();
        go_stopgrant();
        snoop_req = 1'b1;
        clkstop_req_n = 1'b1;
        sleep_req = 1'b1;
        step();
        snoop_req = 1'b0;
        clkstop_req_n = 1'b0;
        sleep_req = 1'b0;
        chk("R5 snoop priority", lp_state, 2);
        step(3);
        chk("R6 snoop hold", lp_state, 2);
        snoop_done = 1'b1;
        step();
        snoop_done = 1'b0;
        chk("R6 snoop return", lp_state, 1);
        intr_req = 1'b1;
        step();
        intr_req = 1'b0;
        chk("R5 intr detour", lp_state, 2);
        intr_latched = 1'b1;
        step();
        intr_latched = 1'b0;
        chk("R6 intr return", lp_state, 1);
    endtask

    task automatic t_sleep_deep();
        dsleep_req_n = 1'b0;
        step(2);
        chk("R8 ignored in stopgrant", lp_state, 1);
        dsleep_req_n = 1'b1;
        sleep_req = 1'b1;
        step();
        chk("R7 sleep entry", lp_state, 3);
        dsleep_req_n = 1'b0;
        step();
        chk("R8 deep entry", lp_state, 4);
        chk("R9 stop permit", clk_stop_ok, 1);
        step(3);
        chk("R9 permit held", clk_stop_ok, 1);
        dsleep_req_n = 1'b1;
        step();
        chk("R10 permit drops", clk_stop_ok, 0);
        step(RESTART_CYC - 1);
        chk("R10 settle not early", lp_state, 4);
        step();
        chk("R10 back to sleep", lp_state, 3);
        sleep_req = 1'b0;
        step();
        chk("R7 sleep exit", lp_state, 1);
        clkstop_req_n = 1'b1;
        step();
        chk("R4 back to normal", lp_state, 0);
    endtask

    task automatic t_platform_reset();
        go_stopgrant();
        sys_rst_n = 1'b0;
        step();
        chk("R11 stays stopgrant", lp_state, 1);
        snoop_req = 1'b1;
        clkstop_req_n = 1'b1;
        step(2);
        snoop_req = 1'b0;
        chk("R11 frozen", lp_state, 1);
        sys_rst_n = 1'b1;
        step();
        chk("R12 clean release", seq_err, 0);
        step();
        chk("R4 after reset", lp_state, 0);
        clkstop_req_n = 1'b0;
        step();
        chk("R2 pending", stop_ack, 1);
        sys_rst_n = 1'b0;
        step();
        chk("R11 ack cleared", stop_ack, 0);
        chk("R11 normal", lp_state, 0);
        sys_rst_n = 1'b1;
        step();
        chk("R12 error set", seq_err, 1);
        clkstop_req_n = 1'b1;
        step(4);
        chk("R12 error sticky", seq_err, 1);
        do_reset();
        chk("R12 cleared by rst", seq_err, 0);
        go_stopgrant();
        sleep_req = 1'b1;
        step();
        sys_rst_n = 1'b0;
        step();
        chk("R11 sleep to normal", lp_state, 0);
        sleep_req = 1'b0;
        clkstop_req_n = 1'b1;
        dreset_req_n = 1'b0;
        step();
        sys_rst_n = 1'b1;
        step();
        chk("R12 deeper reset violation", seq_err, 1);
        dreset_req_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        t_entry_exit();
        t_snoop();
        t_sleep_deep();
        t_platform_reset();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule